// File: doc/BRIEF.md
# Rearrangeable Butterfly Switching Network

This block is the static routing fabric of a small programmable logic array. It carries N single-bit signals from its inputs to its N outputs through a cascade of two-way switch stages joined by butterfly wiring. The network is rearrangeable: a routing program can reach any permutation. It also supports multicast, so one input may feed any number of outputs. The path from an input pin to an output pin holds no register. Its delay is the only timed path in the block.

The network has two stacked planes, each N wires wide. A fan-out stage copies every input onto both planes. There are 2·log2N−1 middle stages. Each middle element pairs two wires of one plane and drives each of its two outputs from either input. A final selector stage picks, for every output, the wire of one plane or the other. Every select bit lives in a configuration register. That register is filled serially on the configuration clock before use and then held. The outputs stay at zero until the whole program is loaded, and the `cfg_done` flag then rises.

With N inputs and L = log2N, the program is CFG_W = (2L−1)·2N + N bits long. For the default N = 8 this is 88 bits.

Top module: `bfly_net`

## Requirements
- R1: A synchronous active-high `rst` on `cfg_clk` clears every configuration bit and the bit counter, and drops `cfg_done`. While `cfg_done` is low, `dout` is all zeros whatever `din` is.
- R2: When `cfg_en` is high at a rising `cfg_clk` edge and `cfg_done` is low, one bit of `cfg_din` is shifted in. `cfg_done` stays low through the first CFG_W−1 shifts and is high after the edge of shift number CFG_W.
- R3: Bit order: the first bit shifted in ends in program position 0, and the last bit shifted in ends in position CFG_W−1.
- R4: Middle stage s (0 ≤ s < 2L−1) pairs wire w with wire w XOR 2^b inside each plane. Here b = L−1−s for s < L and b = s−L+1 otherwise, so the order of b is symmetric about the central stage.
- R5: Middle select at program position s·2N + p·N + w: 0 drives wire w of plane p from the same wire of the previous level, and 1 drives it from its partner wire.
- R6: Output select at program position (2L−1)·2N + j: 0 takes `dout[j]` from wire j of plane 0, and 1 takes it from wire j of plane 1. The fan-out stage puts `din[i]` on wire i of both planes.
- R7: Multicast: a program may route one input to several outputs at once, including all N outputs.
- R8: Once `cfg_done` is high, `cfg_en` and `cfg_din` have no effect on the program until the next reset.
- R9: Once `cfg_done` is high, `dout` follows `din` through the programmed routes with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration bit |
| cfg_done | output | 1 | High once the full program has been loaded |
| din | input | N | Network inputs |
| dout | output | N | Network outputs |

## Verification
The assertions assume that `din` and the configuration inputs change only away from the rising `cfg_clk` edge. They also assume that `rst` is applied before any shift, so that the counter and the chain start from known values. The stimulus drives all inputs on the falling edge. It applies reset at the start and again before each new program. It samples the combinational outputs a quarter period after the rising edge. As a result, every check and every clocked property sees settled values.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  // Butterfly dimension used by middle stage s of a network with l address bits.
  function automatic int unsigned stage_dim(input int unsigned s, input int unsigned l);
    if (s < l) return l - 1 - s;
    else return s - l + 1;
  endfunction

  function automatic int unsigned cfg_width(input int unsigned n);
    int unsigned l;
    l = $clog2(n);
    return (2 * l - 1) * 2 * n + n;
  endfunction
endpackage

// File: rtl/bfly_cfg_chain.sv
module bfly_cfg_chain #(
  parameter int W = 88
) (
  input  logic         cfg_clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic [W-1:0] cfg_bits,
  output logic         cfg_done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  chain;
  logic [CW-1:0] cnt;
  logic          done_q;

  always_ff @(posedge cfg_clk) begin
    if (rst) begin
      chain  <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (cfg_en && !done_q) begin
      chain <= {cfg_din, chain[W-1:1]};
      cnt   <= cnt + 1'b1;
      if (cnt == CW'(W - 1)) done_q <= 1'b1;
    end
  end

  assign cfg_bits = chain;
  assign cfg_done = done_q;

  // R2
  done_sticky_chk: assert property (@(posedge cfg_clk) disable iff (rst)
    cfg_done |=> cfg_done);
  // R8
  chain_frozen_chk: assert property (@(posedge cfg_clk) disable iff (rst)
    cfg_done |=> $stable(cfg_bits));
  // R2
  count_bound_chk: assert property (@(posedge cfg_clk) disable iff (rst)
    cnt <= CW'(W));
  // R2
  done_rise_chk: assert property (@(posedge cfg_clk) disable iff (rst)
    $rose(cfg_done) |-> (cnt == CW'(W)));
endmodule

// File: rtl/bfly_mid_stage.sv
module bfly_mid_stage #(
  parameter int N   = 8,
  parameter int DIM = 0
) (
  input  logic [2*N-1:0] lvl_in,
  input  logic [2*N-1:0] sel,
  output logic [2*N-1:0] lvl_out
);
  localparam int STRIDE = 1 << DIM;

  for (genvar p = 0; p < 2; p++) begin : g_plane
    for (genvar w = 0; w < N; w++) begin : g_wire
      localparam int SELF = p * N + w;
      localparam int MATE = p * N + (w ^ STRIDE);
      assign lvl_out[SELF] = sel[SELF] ? lvl_in[MATE] : lvl_in[SELF];
    end
  end
endmodule

// File: rtl/bfly_out_stage.sv
module bfly_out_stage #(
  parameter int N = 8
) (
  input  logic [2*N-1:0] lvl_in,
  input  logic [N-1:0]   sel,
  input  logic           enable,
  output logic [N-1:0]   dout
);
  for (genvar j = 0; j < N; j++) begin : g_out
    assign dout[j] = enable & (sel[j] ? lvl_in[N+j] : lvl_in[j]);
  end
endmodule

// File: rtl/bfly_net.sv
module bfly_net #(
  parameter int N = 8
) (
  input  logic         cfg_clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic         cfg_done,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  import bfly_pkg::*;

  localparam int L     = $clog2(N);
  localparam int NMID  = 2 * L - 1;
  localparam int SW    = 2 * N;
  localparam int CFG_W = NMID * SW + N;

  initial begin
    n_pow2_chk: assert (N >= 4 && (1 << L) == N);
  end

  logic [CFG_W-1:0] prog;
  logic [SW-1:0]    lvl [0:NMID];

  bfly_cfg_chain #(.W(CFG_W)) u_chain (
    .cfg_clk (cfg_clk),
    .rst     (rst),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .cfg_bits(prog),
    .cfg_done(cfg_done)
  );

  // fan-out stage: every input drives both planes
  assign lvl[0] = {din, din};

  for (genvar s = 0; s < NMID; s++) begin : g_mid
    bfly_mid_stage #(.N(N), .DIM(int'(stage_dim(s, L)))) u_stage (
      .lvl_in (lvl[s]),
      .sel    (prog[s*SW +: SW]),
      .lvl_out(lvl[s+1])
    );
  end

  bfly_out_stage #(.N(N)) u_out (
    .lvl_in(lvl[NMID]),
    .sel   (prog[NMID*SW +: N]),
    .enable(cfg_done),
    .dout  (dout)
  );

  // R1
  gate_low_chk: assert property (@(posedge cfg_clk) disable iff (rst)
    !cfg_done |-> (dout == '0));
  // R9
  identity_chk: assert property (@(posedge cfg_clk) disable iff (rst)
    (cfg_done && prog == '0) |-> (dout == din));
  // R6
  plane1_straight_chk: assert property (@(posedge cfg_clk) disable iff (rst)
    (cfg_done && prog[NMID*SW-1:0] == '0) |-> (dout == din));
endmodule

// File: tb/tb_bfly_net.sv
module tb_bfly_net;
  localparam int N     = 8;
  localparam int L     = 3;
  localparam int NMID  = 2 * L - 1;
  localparam int SW    = 2 * N;
  localparam int CFG_W = NMID * SW + N;

  logic         cfg_clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_en = 1'b0;
  logic         cfg_din = 1'b0;
  logic         cfg_done;
  logic [N-1:0] din = '0;
  logic [N-1:0] dout;

  int errors = 0;
  int checks = 0;

  logic [N-1:0] exp_q [$];
  string        tag_q [$];

  bfly_net #(.N(N)) dut (
    .cfg_clk(cfg_clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_done(cfg_done), .din(din), .dout(dout)
  );

  always #10 cfg_clk = ~cfg_clk;

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Reference routing model built from R4, R5 and R6
  function automatic logic [N-1:0] model(input logic [CFG_W-1:0] c, input logic [N-1:0] x);
    logic [SW-1:0] cur, nxt;
    logic [N-1:0]  r;
    int            b;
    cur = {x, x};
    for (int s = 0; s < NMID; s++) begin
      b = (s < L) ? (L - 1 - s) : (s - L + 1);
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < N; w++)
          nxt[p*N+w] = c[s*SW+p*N+w] ? cur[p*N+(w ^ (1 << b))] : cur[p*N+w];
      cur = nxt;
    end
    for (int j = 0; j < N; j++) r[j] = c[NMID*SW+j] ? cur[N+j] : cur[j];
    return r;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge cfg_clk);
    rst = 1'b1;
    cfg_en = 1'b0;
    @(negedge cfg_clk);
    rst = 1'b0;
  endtask

  // R2 R3: bit 0 of the program is shifted in first
  task automatic load(input logic [CFG_W-1:0] c);
    for (int k = 0; k < CFG_W; k++) begin
      @(negedge cfg_clk);
      cfg_en = 1'b1;
      cfg_din = c[k];
      if (k == CFG_W - 1) check("R2 done low before last shift", {7'd0, cfg_done}, 8'd0);
    end
    @(negedge cfg_clk);
    cfg_en = 1'b0;
    check("R2 done after last shift", {7'd0, cfg_done}, 8'd1);
  endtask

  // driver: drives an input vector and queues the expected output
  task automatic apply(input string tag, input logic [N-1:0] x, input logic [N-1:0] e);
    @(negedge cfg_clk);
    din = x;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compares a quarter period after the rising edge
  always @(posedge cfg_clk) begin
    #5;
    if (exp_q.size() > 0) check(tag_q.pop_front(), dout, exp_q.pop_front());
  end

  task automatic drain();
    while (exp_q.size() > 0) @(negedge cfg_clk);
    @(negedge cfg_clk);
  endtask

  task automatic run_random(input string tag, input logic [CFG_W-1:0] c, input int cnt);
    logic [N-1:0] x;
    for (int i = 0; i < cnt; i++) begin
      x = N'($urandom);
      apply(tag, x, model(c, x));
    end
    drain();
  endtask

  initial begin
    logic [CFG_W-1:0] c;
    logic [N-1:0]     x;

    do_reset();
    // R1: reset state
    check("R1 done low after reset", {7'd0, cfg_done}, 8'd0);
    din = 8'hA5;
    #1;
    check("R1 outputs zero before load", dout, 8'h00);

    // R1: partial program keeps outputs at zero
    for (int k = 0; k < 20; k++) begin
      @(negedge cfg_clk);
      cfg_en = 1'b1;
      cfg_din = 1'b0;
    end
    @(negedge cfg_clk);
    cfg_en = 1'b0;
    apply("R1 partial load gated", 8'hFF, 8'h00);
    drain();

    // R9: all-straight program is the identity
    do_reset();
    c = '0;
    load(c);
    for (int i = 0; i < 6; i++) begin
      x = N'($urandom);
      apply("R9 identity route", x, x);
    end
    drain();

    // R8: shifts after done are ignored
    for (int k = 0; k < 12; k++) begin
      @(negedge cfg_clk);
      cfg_en = 1'b1;
      cfg_din = 1'b1;
    end
    @(negedge cfg_clk);
    cfg_en = 1'b0;
    apply("R8 program frozen", 8'h3C, 8'h3C);
    apply("R8 program frozen", 8'hC1, 8'hC1);
    drain();

    // R6: outputs from plane 1, straight mid stages
    do_reset();
    c = '0;
    c[NMID*SW +: N] = '1;
    load(c);
    apply("R6 plane1 straight", 8'h96, 8'h96);
    apply("R6 plane1 straight", 8'h01, 8'h01);
    drain();

    // R7: broadcast din[0] through plane 0 to all outputs
    do_reset();
    c = '0;
    for (int s = 0; s < L; s++)
      for (int w = 0; w < N; w++)
        if (w[L-1-s]) c[s*SW + w] = 1'b1;
    load(c);
    apply("R7 broadcast in0 high", 8'h01, 8'hFF);
    apply("R7 broadcast in0 low", 8'hFE, 8'h00);
    apply("R7 broadcast in0 high", 8'h55, 8'hFF);
    drain();

    // R4 R5: single cross in the last stage (dim 2) of plane 0 swaps halves
    do_reset();
    c = '0;
    c[(NMID-1)*SW +: N] = '1;
    load(c);
    apply("R4 last stage swap", 8'h0F, 8'hF0);
    apply("R4 last stage swap", 8'h12, 8'h21);
    drain();

    // R4 R5 R6 R7: random programs against the reference model
    for (int r = 0; r < 4; r++) begin
      do_reset();
      for (int k = 0; k < CFG_W; k++) c[k] = 1'($urandom);
      load(c);
      run_random("R5 random program", c, 8);
    end

    // R1: reset after a load clears the program and gates outputs
    do_reset();
    check("R1 done cleared by reset", {7'd0, cfg_done}, 8'd0);
    apply("R1 gated after reset", 8'hFF, 8'h00);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule